// File: doc/BRIEF.md
# GPIO Bank with Edge Interrupts

The block is one bank of 32 general-purpose pins behind a simple register bus. The bus uses word addresses, a single write strobe and read data that follows the address with no wait cycles. Software drives outputs through an output latch. Each pin has a direction bit, a pull-disable bit and an alternate-function select bit. The latch and the direction register each have write-one set and write-one clear aliases, so a single pin can be changed without a read-modify-write sequence. On an input pin whose pull is enabled, the latch value picks the pull direction.

Pad inputs pass through a two-flop synchronizer. The synchronized levels feed an edge detector. A pin has separate rising-edge and falling-edge enable masks, and an enabled edge sets a sticky status bit. Software clears status bits by writing ones. A single registered interrupt line reports that at least one status bit is pending.

Top module: `gpio_edge_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` = 0). The latch, the alternate select, the pull-disable, both edge masks and the status are all zero, and `irq` is 0. As a result `pad_pull_en` is all ones and `pad_pull_up` is all zeros.
- R2: The word addresses are:

  | Word | Register | Access |
  |---|---|---|
  | 0 | latch / pin level | read and write |
  | 1 | latch set | write only |
  | 2 | latch clear | write only |
  | 3 | pull-disable | read and write |
  | 4 | direction | read and write |
  | 5 | direction set | write only |
  | 6 | direction clear | write only |
  | 8 | alternate select | read and write |
  | 16 | rising mask | read and write |
  | 17 | falling mask | read and write |
  | 18 | status | read only |
  | 19 | status clear | write only |

  Unmapped words read as zero.
- R3: A write to word 0 loads the latch. In a write to word 1, each one bit sets the matching latch bit. In a write to word 2, each one bit clears the matching latch bit. Zero bits in word 1 and word 2 writes leave the latch bit as it was.
- R4: Word 5 sets direction bits and word 6 clears them, with the same write-one rule as R3. A direction bit of 1 makes the pin an output, and `pad_oe` follows the direction register.
- R5: For an input pin with pull-disable 0, `pad_pull_en` is 1 and `pad_pull_up` equals the latch bit (1 = pull-up, 0 = pull-down). A pull-disable bit of 1 turns the pull off. An output pin never has its pull enabled.
- R6: When a pin's alternate-select bit is 1, `pad_oe`, `pad_out` and `pad_pull_en` for that pin are 0, and `alt_sel` shows that bit as 1.
- R7: Reading word 0 gives the latch bit for output pins. For input pins it gives the pad level, which appears two clock edges after the pad changes.
- R8: A synchronized rising edge on a pin whose rising-mask bit is set latches that pin's status bit. Falling edges work the same way with the falling mask. Both masks may be set together. An edge on a pin whose mask bit for that edge is clear is ignored. The status bit becomes visible three edges after the pad changes.
- R9: Writing ones to word 19 clears the matching status bits. If an enabled edge on a pin arrives in the same cycle as a clear for that pin, the status bit stays set.
- R10: `irq` is a registered OR of all status bits. It follows the status one cycle later, both when a bit is set and when the last bit is cleared.
- R11: The write-only words (1, 2, 5, 6, 19) read as zero. Writes to the status word (18) have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output value |
| pad_oe | output | 32 | Pad output enable |
| pad_pull_en | output | 32 | Pad pull enable |
| pad_pull_up | output | 32 | Pull direction: 1 = up, 0 = down |
| alt_sel | output | 32 | Pin handed to the alternate peripheral |
| irq | output | 1 | Combined interrupt |

## Verification
The bound checker watches several properties on every cycle:
- Direction-set and direction-clear writes land as OR and AND-NOT.
- Pending status bits stay set until a clear names them.
- No status bit appears on a pin whose edge masks are both off.
- `irq` follows the OR of the status with a one-cycle lag.
- Pins handed to the alternate function, and output pins, never have a driven pad or an active pull.

Some behaviours can only be shown by the bench's scenarios:
- the exact cycle in which a pad change reaches a read or a status bit;
- the edge-wins rule when an edge and a clear meet in the same cycle;
- the zero readback of the write-only words;
- the pull direction taken from the latch.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int unsigned PIN_W  = 32;
    localparam int unsigned ADDR_W = 5;

    typedef enum logic [ADDR_W-1:0] {
        RG_LATCH   = 5'd0,
        RG_LSET    = 5'd1,
        RG_LCLR    = 5'd2,
        RG_NOPULL  = 5'd3,
        RG_DIR     = 5'd4,
        RG_DSET    = 5'd5,
        RG_DCLR    = 5'd6,
        RG_ALT     = 5'd8,
        RG_RISE_EN = 5'd16,
        RG_FALL_EN = 5'd17,
        RG_PEND    = 5'd18,
        RG_ACK     = 5'd19
    } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    localparam int CHAIN_W = W * STAGES;

    generate
        if (STAGES == 1) begin : g_one
            logic [W-1:0] r_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) r_q <= '0;
                else        r_q <= d;
            end
            assign q = r_q;
        end else begin : g_chain
            logic [CHAIN_W-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[CHAIN_W-W-1:0], d};
            end
            assign q = chain_q[CHAIN_W-1 -: W];
        end
    endgenerate
endmodule

// File: rtl/gpio_regfile.sv
module gpio_regfile
    import gpio_bank_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wdata,
    output logic [W-1:0]  latch_q,
    output logic [W-1:0]  dir_q,
    output logic [W-1:0]  nopull_q,
    output logic [W-1:0]  alt_q,
    output logic [W-1:0]  rise_en_q,
    output logic [W-1:0]  fall_en_q,
    output logic [W-1:0]  ack_vec
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            latch_q <= '0;
        end else if (wr) begin
            if (addr == RG_LATCH)     latch_q <= wdata;
            else if (addr == RG_LSET) latch_q <= latch_q | wdata;
            else if (addr == RG_LCLR) latch_q <= latch_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
        end else if (wr) begin
            if (addr == RG_DIR)       dir_q <= wdata;
            else if (addr == RG_DSET) dir_q <= dir_q | wdata;
            else if (addr == RG_DCLR) dir_q <= dir_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nopull_q  <= '0;
            alt_q     <= '0;
            rise_en_q <= '0;
            fall_en_q <= '0;
        end else if (wr) begin
            if (addr == RG_NOPULL)  nopull_q  <= wdata;
            if (addr == RG_ALT)     alt_q     <= wdata;
            if (addr == RG_RISE_EN) rise_en_q <= wdata;
            if (addr == RG_FALL_EN) fall_en_q <= wdata;
        end
    end

    always_comb begin
        ack_vec = '0;
        if (wr && addr == RG_ACK) ack_vec = wdata;
    end
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_en,
    input  logic [W-1:0] fall_en,
    input  logic [W-1:0] ack_vec,
    output logic [W-1:0] pend_q,
    output logic         irq_q
);
    logic [W-1:0] lvl_prev_q;
    logic [W-1:0] hit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_prev_q <= '0;
        else        lvl_prev_q <= lvl;
    end

    always_comb begin
        hit = ((lvl & ~lvl_prev_q) & rise_en) | ((~lvl & lvl_prev_q) & fall_en);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            pend_q <= (pend_q & ~ack_vec) | hit;
            irq_q  <= |pend_q;
        end
    end
endmodule

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_bank_pkg::*;
#(
    parameter int W           = PIN_W,
    parameter int AW          = ADDR_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [W-1:0]  bus_wdata,
    output logic [W-1:0]  bus_rdata,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe,
    output logic [W-1:0]  pad_pull_en,
    output logic [W-1:0]  pad_pull_up,
    output logic [W-1:0]  alt_sel,
    output logic          irq
);
    logic [W-1:0] latch_q, dir_q, nopull_q, alt_q;
    logic [W-1:0] rise_en_q, fall_en_q, ack_vec;
    logic [W-1:0] lvl_s, pend_q;
    logic         irq_q;

    gpio_regfile #(.W(W), .AW(AW)) regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .latch_q   (latch_q),
        .dir_q     (dir_q),
        .nopull_q  (nopull_q),
        .alt_q     (alt_q),
        .rise_en_q (rise_en_q),
        .fall_en_q (fall_en_q),
        .ack_vec   (ack_vec)
    );

    gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pad_in),
        .q     (lvl_s)
    );

    gpio_edge_irq #(.W(W)) edge_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl     (lvl_s),
        .rise_en (rise_en_q),
        .fall_en (fall_en_q),
        .ack_vec (ack_vec),
        .pend_q  (pend_q),
        .irq_q   (irq_q)
    );

    always_comb begin
        pad_oe      = dir_q & ~alt_q;
        pad_out     = latch_q & ~alt_q;
        pad_pull_en = ~dir_q & ~nopull_q & ~alt_q;
        pad_pull_up = pad_pull_en & latch_q;
        alt_sel     = alt_q;
        irq         = irq_q;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RG_LATCH:   bus_rdata = (dir_q & latch_q) | (~dir_q & lvl_s);
            RG_NOPULL:  bus_rdata = nopull_q;
            RG_DIR:     bus_rdata = dir_q;
            RG_ALT:     bus_rdata = alt_q;
            RG_RISE_EN: bus_rdata = rise_en_q;
            RG_FALL_EN: bus_rdata = fall_en_q;
            RG_PEND:    bus_rdata = pend_q;
            default:    bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_edge_bank_chk.sv
module gpio_edge_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int W  = 32,
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [W-1:0]  bus_wdata,
    input logic [W-1:0]  dir_q,
    input logic [W-1:0]  alt_q,
    input logic [W-1:0]  rise_en_q,
    input logic [W-1:0]  fall_en_q,
    input logic [W-1:0]  pend_q,
    input logic          irq,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  pad_pull_en
);
    logic [W-1:0] ack_seen;
    assign ack_seen = (bus_wr && bus_addr == RG_ACK) ? bus_wdata : '0;

    a_r4_dir_set: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_DSET) |=> dir_q == ($past(dir_q) | $past(bus_wdata)));

    a_r4_dir_clr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == RG_DCLR) |=> dir_q == ($past(dir_q) & ~$past(bus_wdata)));

    a_r9_pend_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q & ($past(pend_q) & ~$past(ack_seen))) == ($past(pend_q) & ~$past(ack_seen)));

    a_r8_no_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (pend_q & ~$past(pend_q) & ~($past(rise_en_q) | $past(fall_en_q))) == '0);

    a_r10_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> irq == (|$past(pend_q)));

    a_r6_alt_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe | pad_pull_en) & alt_q) == '0);

    a_r5_no_pull_on_out: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pull_en & pad_oe) == '0);
endmodule

bind gpio_edge_bank gpio_edge_bank_chk #(.W(W), .AW(AW)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .dir_q       (dir_q),
    .alt_q       (alt_q),
    .rise_en_q   (rise_en_q),
    .fall_en_q   (fall_en_q),
    .pend_q      (pend_q),
    .irq         (irq),
    .pad_oe      (pad_oe),
    .pad_pull_en (pad_pull_en)
);

// File: tb/gpio_edge_bank_tb_top.sv
`timescale 1ns/1ps
module gpio_edge_bank_tb_top;
    localparam int W = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [W-1:0]  bus_wdata = '0;
    logic [W-1:0]  bus_rdata;
    logic [W-1:0]  pad_in = '0;
    logic [W-1:0]  pad_out, pad_oe, pad_pull_en, pad_pull_up, alt_sel;
    logic          irq;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #2.5 clk = ~clk;

    gpio_edge_bank dut_i (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pull_en(pad_pull_en),
        .pad_pull_up(pad_pull_up), .alt_sel(alt_sel), .irq(irq)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [W-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [W-1:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic t_reset();
        logic [W-1:0] v;
        chk("R1 pad_oe", pad_oe, '0);
        chk("R1 pad_out", pad_out, '0);
        chk("R1 pull_en", pad_pull_en, '1);
        chk("R1 pull_up", pad_pull_up, '0);
        chk("R1 alt_sel", alt_sel, '0);
        chk("R1 irq", {31'd0, irq}, '0);
        rd(5'd18, v); chk("R1 status", v, '0);
        rd(5'd16, v); chk("R1 rise mask", v, '0);
        rd(5'd17, v); chk("R1 fall mask", v, '0);
    endtask

    task automatic t_latch();
        logic [W-1:0] v;
        wr(5'd5, 32'hFFFF_FFFF);
        wr(5'd0, 32'h1234_5678);
        rd(5'd0, v); chk("R3 R2 latch load", v, 32'h1234_5678);
        wr(5'd1, 32'h0000_000F);
        rd(5'd0, v); chk("R3 latch set", v, 32'h1234_567F);
        wr(5'd2, 32'h1200_0000);
        rd(5'd0, v); chk("R3 latch clear", v, 32'h0034_567F);
        chk("R3 pad_out", pad_out, 32'h0034_567F);
        rd(5'd1, v); chk("R11 set alias reads 0", v, '0);
        rd(5'd2, v); chk("R11 clr alias reads 0", v, '0);
    endtask

    task automatic t_dir();
        logic [W-1:0] v;
        wr(5'd6, 32'hFFFF_0000);
        rd(5'd4, v); chk("R4 dir clear", v, 32'h0000_FFFF);
        wr(5'd5, 32'h0001_0000);
        rd(5'd4, v); chk("R4 dir set", v, 32'h0001_FFFF);
        chk("R4 pad_oe", pad_oe, 32'h0001_FFFF);
        rd(5'd5, v); chk("R11 dir set reads 0", v, '0);
    endtask

    task automatic t_pull();
        wr(5'd3, 32'h00F0_0000);
        chk("R5 pull_en", pad_pull_en, 32'hFF0E_0000);
        chk("R5 pull_up", pad_pull_up, 32'h0004_0000);
    endtask

    task automatic t_alt();
        logic [W-1:0] v;
        wr(5'd8, 32'h0000_000F);
        chk("R6 alt_sel", alt_sel, 32'h0000_000F);
        chk("R6 pad_oe", pad_oe, 32'h0001_FFF0);
        chk("R6 pad_out", pad_out, 32'h0034_5670);
        rd(5'd8, v); chk("R6 alt readback", v, 32'h0000_000F);
        wr(5'd8, 32'h0);
    endtask

    task automatic t_input_read();
        logic [W-1:0] v;
        wr(5'd6, 32'hFFFF_FFFF);
        @(negedge clk);
        pad_in = 32'hA5A5_0F0F;
        @(negedge clk);
        rd(5'd0, v); chk("R7 one edge old", v, 32'h0);
        @(negedge clk);
        rd(5'd0, v); chk("R7 two edges new", v, 32'hA5A5_0F0F);
        pad_in = 32'h0;
        repeat (4) @(negedge clk);
        rd(5'd18, v); chk("R8 masks off no status", v, '0);
    endtask

    task automatic t_edges();
        logic [W-1:0] v;
        wr(5'd16, 32'h0000_0001);
        wr(5'd17, 32'h0000_0002);
        @(negedge clk);
        pad_in = 32'h0000_0003;
        repeat (2) @(negedge clk);
        rd(5'd18, v); chk("R8 not before third edge", v, '0);
        @(negedge clk);
        rd(5'd18, v); chk("R8 rising latched", v, 32'h1);
        chk("R10 irq lags", {31'd0, irq}, '0);
        @(negedge clk);
        chk("R10 irq set", {31'd0, irq}, 32'h1);
        pad_in = 32'h0000_0001;
        repeat (3) @(negedge clk);
        rd(5'd18, v); chk("R8 falling latched", v, 32'h3);
        pad_in = 32'h0;
        repeat (3) @(negedge clk);
        rd(5'd18, v); chk("R8 unmasked fall ignored", v, 32'h3);
        wr(5'd19, 32'h1);
        rd(5'd18, v); chk("R9 clear one", v, 32'h2);
        rd(5'd19, v); chk("R11 clear reads 0", v, '0);
        wr(5'd18, 32'hFFFF_FFFF);
        rd(5'd18, v); chk("R11 status write ignored", v, 32'h2);
        wr(5'd19, 32'hFFFF_FFFF);
        rd(5'd18, v); chk("R9 clear all", v, '0);
        chk("R10 irq still high", {31'd0, irq}, 32'h1);
        @(negedge clk);
        chk("R10 irq drops", {31'd0, irq}, '0);
    endtask

    task automatic t_both_and_race();
        logic [W-1:0] v;
        wr(5'd16, 32'h0000_0100);
        wr(5'd17, 32'h0000_0100);
        @(negedge clk);
        pad_in = 32'h0000_0100;
        repeat (3) @(negedge clk);
        rd(5'd18, v); chk("R8 both masks rise", v, 32'h100);
        wr(5'd19, 32'h100);
        pad_in = 32'h0;
        repeat (3) @(negedge clk);
        rd(5'd18, v); chk("R8 both masks fall", v, 32'h100);
        pad_in = 32'h0000_0100;
        repeat (2) @(negedge clk);
        bus_wr = 1'b1; bus_addr = 5'd19; bus_wdata = 32'h100;
        @(negedge clk);
        bus_wr = 1'b0;
        rd(5'd18, v); chk("R9 edge beats clear", v, 32'h100);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_latch();
        t_dir();
        t_pull();
        t_alt();
        t_input_read();
        t_edges();
        t_both_and_race();
        done = 1'b1;
        summary();
    end
endmodule